// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block keeps the one reservation that backs a processor's load-and-reserve and store-conditional word operations. A load-and-reserve reads a word and marks the aligned granule that holds it as reserved. A later store-conditional may write memory only while that reservation still stands. The block raises a one-cycle done strobe for each store-conditional, together with a success flag.

Toward the local core the reservation does not depend on address: any store-conditional ends it. Toward the rest of the system it is tied to one granule, 16 bytes by default. A write from another bus master into that granule clears it. So does a write from the on-chip peripheral master. Two external cancel pins also clear it, which lets logic outside the block void the reservation for traffic the block cannot see. The live reservation state is always driven on an output.

The local request port drives the memory strobes directly and in the same cycle. Plain loads and stores pass through to memory and leave the reservation alone.

Top module: `lrsc_resv_unit`

## Requirements
- R1: While reset is held and right after it, `resv_valid`, `sc_done` and `sc_success` are 0.
- R2: A load-and-reserve (`req_op` = 3) drives `mem_rd` in the same cycle. `mem_addr` is the request address with bits 1:0 forced to zero. From the next cycle `resv_valid` is 1 and the granule of the address is recorded.
- R3: A store-conditional (`req_op` = 4) issued while the reservation is valid, with no same-cycle cancel event, drives `mem_we` in the same cycle with its own address and data. Its address is never compared with the reserved granule. One cycle later `sc_done` = 1 and `sc_success` = 1.
- R4: A store-conditional issued with no valid reservation does not assert `mem_we`. One cycle later `sc_done` = 1 and `sc_success` = 0.
- R5: Every store-conditional leaves `resv_valid` at 0 from the next cycle, whether it succeeds or fails.
- R6: A write reported on snoop port 0 (another bus master) or snoop port 1 (the on-chip peripheral master) clears the reservation from the next cycle when its address bits above bit 3 match the reserved granule. A write outside the granule has no effect.
- R7: When either bit of `cancel_in` is 1, `resv_valid` is 0 from the next cycle.
- R8: A store-conditional fails and writes nothing if, in its own cycle, a cancel pin is high or a snoop write hits the reserved granule.
- R9: A new load-and-reserve replaces the old granule. When it meets a cancel event in the same cycle, it still takes effect if the event only hits the old granule. A cancel pin, or a snoop write that hits the new granule, leaves no reservation.
- R10: A plain load (`req_op` = 1) asserts `mem_rd`. A plain store (`req_op` = 2) asserts `mem_we`. Neither one changes `resv_valid`.
- R11: `sc_done` pulses for exactly one cycle, one cycle after each store-conditional, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present this cycle |
| req_op | input | 3 | 1 load, 2 store, 3 load-and-reserve, 4 store-conditional |
| req_addr | input | ADDR_W | Byte address of the word |
| req_wdata | input | DATA_W | Store data |
| snp_valid | input | NUM_SNOOP | Foreign write seen, one bit per snoop port |
| snp_addr | input | NUM_SNOOP*ADDR_W | Foreign write addresses, port i in slice i |
| cancel_in | input | NUM_CANCEL | External cancel pins, active high |
| resv_valid | output | 1 | Reservation currently held |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| sc_done | output | 1 | Store-conditional completed |
| sc_success | output | 1 | Store-conditional result, valid with sc_done |

## Verification
The assertions assume `req_op` only takes the five listed codes. They also assume the cancel pins and snoop inputs are driven to known values in every cycle after reset, because the clear and stability properties read them in the same cycle. The stimulus drives every input at each falling edge, and it returns snoop and cancel inputs to zero between operations unless a case needs them. This keeps each same-cycle collision in R8 and R9 a deliberate, single event.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_LOAD   = 3'd1,
      OP_STORE  = 3'd2,
      OP_LDRSV  = 3'd3,
      OP_STCOND = 3'd4
   } lrsc_op_e;

   function automatic logic [63:0] granule_mask(input int unsigned gran_log2);
      return ~((64'd1 << gran_log2) - 64'd1);
   endfunction
endpackage

// File: rtl/lrsc_region_cmp.sv
module lrsc_region_cmp #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned GRAN_LOG2 = 4
) (
   input  logic              probe_vld,
   input  logic [ADDR_W-1:0] probe_addr,
   input  logic [ADDR_W-1:0] base_addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] GMASK = ADDR_W'(lrsc_pkg::granule_mask(GRAN_LOG2));

   always_comb begin
      hit = probe_vld && ((probe_addr & GMASK) == (base_addr & GMASK));
   end
endmodule

// File: rtl/lrsc_snoop_filter.sv
module lrsc_snoop_filter #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned GRAN_LOG2 = 4,
   parameter int unsigned NUM_SNOOP = 2
) (
   input  logic [NUM_SNOOP-1:0]        snp_valid,
   input  logic [NUM_SNOOP*ADDR_W-1:0] snp_addr,
   input  logic                        old_vld,
   input  logic [ADDR_W-1:0]           old_base,
   input  logic [ADDR_W-1:0]           new_base,
   output logic                        hit_old,
   output logic                        hit_new
);
   logic [NUM_SNOOP-1:0] old_vec;
   logic [NUM_SNOOP-1:0] new_vec;

   for (genvar i = 0; i < NUM_SNOOP; i++) begin : g_port
      logic [ADDR_W-1:0] port_addr;
      assign port_addr = snp_addr[i*ADDR_W +: ADDR_W];

      lrsc_region_cmp #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_cmp_old (
         .probe_vld (snp_valid[i] && old_vld),
         .probe_addr(port_addr),
         .base_addr (old_base),
         .hit       (old_vec[i])
      );

      lrsc_region_cmp #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_cmp_new (
         .probe_vld (snp_valid[i]),
         .probe_addr(port_addr),
         .base_addr (new_base),
         .hit       (new_vec[i])
      );
   end

   assign hit_old = |old_vec;
   assign hit_new = |new_vec;
endmodule

// File: rtl/lrsc_resv_state.sv
module lrsc_resv_state #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned GRAN_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              load_ok,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              drop,
   output logic              valid_q,
   output logic [ADDR_W-1:0] base_q
);
   localparam logic [ADDR_W-1:0] GMASK = ADDR_W'(lrsc_pkg::granule_mask(GRAN_LOG2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         base_q  <= '0;
      end else if (load_en) begin
         valid_q <= load_ok;
         base_q  <= load_addr & GMASK;
      end else if (drop) begin
         valid_q <= 1'b0;
      end
   end

   assert_load_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && load_ok) |=> (valid_q && base_q == ($past(load_addr) & GMASK)));

   assert_drop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !load_en) |=> !valid_q);

   assert_base_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(base_q));
endmodule

// File: rtl/lrsc_resv_unit.sv
module lrsc_resv_unit #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned GRAN_LOG2  = 4,
   parameter int unsigned NUM_SNOOP  = 2,
   parameter int unsigned NUM_CANCEL = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [2:0]                  req_op,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   input  logic [NUM_SNOOP-1:0]        snp_valid,
   input  logic [NUM_SNOOP*ADDR_W-1:0] snp_addr,
   input  logic [NUM_CANCEL-1:0]       cancel_in,
   output logic                        resv_valid,
   output logic                        mem_rd,
   output logic                        mem_we,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [DATA_W-1:0]           mem_wdata,
   output logic                        sc_done,
   output logic                        sc_success
);
   import lrsc_pkg::*;

   localparam logic [ADDR_W-1:0] WORD_MASK = ~(ADDR_W'(3));

   if (GRAN_LOG2 < 2 || GRAN_LOG2 >= ADDR_W) begin : g_bad_gran
      $error("GRAN_LOG2 must lie between 2 and ADDR_W-1");
   end
   if (NUM_SNOOP < 1 || NUM_CANCEL < 1) begin : g_bad_count
      $error("NUM_SNOOP and NUM_CANCEL must be at least 1");
   end
   if (ADDR_W > 64) begin : g_bad_addr
      $error("ADDR_W above 64 is not supported");
   end

   logic              is_load, is_store, is_ldrsv, is_stcond;
   logic              pin_cancel, hit_old, hit_new, kill_old;
   logic              ld_ok, sc_ok;
   logic              valid_q;
   logic [ADDR_W-1:0] base_q;
   logic              done_q, succ_q;

   always_comb begin
      is_load   = req_valid && (req_op == OP_LOAD);
      is_store  = req_valid && (req_op == OP_STORE);
      is_ldrsv  = req_valid && (req_op == OP_LDRSV);
      is_stcond = req_valid && (req_op == OP_STCOND);
   end

   assign pin_cancel = |cancel_in;

   lrsc_snoop_filter #(
      .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .NUM_SNOOP(NUM_SNOOP)
   ) u_snoop (
      .snp_valid(snp_valid),
      .snp_addr (snp_addr),
      .old_vld  (valid_q),
      .old_base (base_q),
      .new_base (req_addr),
      .hit_old  (hit_old),
      .hit_new  (hit_new)
   );

   assign kill_old = pin_cancel || hit_old;
   assign ld_ok    = !pin_cancel && !hit_new;
   assign sc_ok    = valid_q && !kill_old;

   lrsc_resv_state #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (is_ldrsv),
      .load_ok  (ld_ok),
      .load_addr(req_addr),
      .drop     (is_stcond || kill_old),
      .valid_q  (valid_q),
      .base_q   (base_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         succ_q <= 1'b0;
      end else begin
         done_q <= is_stcond;
         succ_q <= is_stcond && sc_ok;
      end
   end

   always_comb begin
      resv_valid = valid_q;
      mem_rd     = is_load || is_ldrsv;
      mem_we     = is_store || (is_stcond && sc_ok);
      mem_addr   = req_addr & WORD_MASK;
      mem_wdata  = req_wdata;
      sc_done    = done_q;
      sc_success = succ_q;
   end

   assert_sc_write_needs_resv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_STCOND && mem_we) |-> (resv_valid && !pin_cancel));

   assert_sc_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_STCOND) |=> !resv_valid);

   assert_snoop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_old && !(req_valid && req_op == OP_LDRSV)) |=> !resv_valid);

   assert_pin_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pin_cancel |=> !resv_valid);

   assert_success_implies_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sc_success |-> sc_done);

   assert_done_follows_sc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sc_done |-> $past(req_valid && req_op == OP_STCOND));

   assert_plain_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_valid && (req_op == OP_LOAD || req_op == OP_STORE) || !req_valid)
       && !pin_cancel && !hit_old) |=> $stable(resv_valid));

   assert_fresh_resv_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_LDRSV && !pin_cancel && !hit_new) |=> resv_valid);
endmodule

// File: tb/lrsc_resv_unit_tb.sv
module lrsc_resv_unit_tb;
   localparam int CLK_P = 10;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op = 3'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    snp_valid = '0;
   logic [2*AW-1:0] snp_addr = '0;
   logic [1:0]    cancel_in = '0;
   logic          resv_valid, mem_rd, mem_we, sc_done, sc_success;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   bit          exp_valid = 1'b0;
   logic [AW-1:0] exp_base = '0;
   bit          sb_q[$];

   always #(CLK_P/2) clk = ~clk;

   lrsc_resv_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .snp_valid(snp_valid),
      .snp_addr(snp_addr), .cancel_in(cancel_in), .resv_valid(resv_valid),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .sc_done(sc_done), .sc_success(sc_success)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit same_gran(input logic [AW-1:0] a, input logic [AW-1:0] b);
      return (a >> 4) == (b >> 4);
   endfunction

   // Monitor: pops the scoreboard whenever a store-conditional result appears (R11).
   always @(negedge clk) begin
      if (rst_n && sc_done) begin
         if (sb_q.size() == 0) chk("R11 unexpected sc_done", 1, 0);
         else chk("R3/R4 sc_success", sc_success, sb_q.pop_front());
      end
   end

   task automatic apply(input string tag, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [1:0] sv,
                        input logic [AW-1:0] sa0, input logic [AW-1:0] sa1,
                        input logic [1:0] cn);
      bit pin, h_old, h_new, e_we, e_rd;
      @(negedge clk);
      pin   = |cn;
      h_old = exp_valid && ((sv[0] && same_gran(sa0, exp_base)) || (sv[1] && same_gran(sa1, exp_base)));
      h_new = (sv[0] && same_gran(sa0, a)) || (sv[1] && same_gran(sa1, a));
      e_rd  = (op == 3'd1) || (op == 3'd3);
      e_we  = (op == 3'd2) || (op == 3'd4 && exp_valid && !pin && !h_old);
      if (op == 3'd4) sb_q.push_back(e_we);
      if (op == 3'd3) begin
         exp_valid = !pin && !h_new;
         exp_base  = a;
      end else if (op == 3'd4 || pin || h_old) begin
         exp_valid = 1'b0;
      end
      req_valid = (op != 3'd0); req_op = op; req_addr = a; req_wdata = d;
      snp_valid = sv; snp_addr = {sa1, sa0}; cancel_in = cn;
      #1;
      chk({tag, " mem_we"}, mem_we, e_we);
      chk({tag, " mem_rd"}, mem_rd, e_rd);
      if (e_we || e_rd) chk({tag, " mem_addr"}, mem_addr, a & ~32'h3);
      if (e_we) chk({tag, " mem_wdata"}, mem_wdata, d);
      @(posedge clk); #1;
      chk({tag, " resv_valid"}, resv_valid, exp_valid);
      @(negedge clk);
      req_valid = 1'b0; req_op = 3'd0; snp_valid = '0; cancel_in = '0;
   endtask

   task automatic op1(input string tag, input logic [2:0] op, input logic [AW-1:0] a);
      apply(tag, op, a, a ^ 32'hA5A5_0000, 2'b00, '0, '0, 2'b00);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         chk("watchdog expired", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 resv_valid in reset", resv_valid, 0);
      chk("R1 sc_done in reset", sc_done, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 resv_valid after reset", resv_valid, 0);
      chk("R1 sc_success after reset", sc_success, 0);

      op1("R4 sc without reservation", 3'd4, 32'h100);
      op1("R2 load-reserve", 3'd3, 32'h103);
      op1("R10 plain load", 3'd1, 32'h100);
      op1("R10 plain store", 3'd2, 32'h104);
      op1("R3 R5 sc other address", 3'd4, 32'h500);
      op1("R4 R5 second sc fails", 3'd4, 32'h100);

      op1("R2 reserve 0x200", 3'd3, 32'h200);
      apply("R6 bus snoop same granule", 3'd0, 0, 0, 2'b01, 32'h20C, 0, 2'b00);
      op1("R2 reserve 0x200", 3'd3, 32'h200);
      apply("R6 bus snoop next granule", 3'd0, 0, 0, 2'b01, 32'h210, 0, 2'b00);
      apply("R6 on-chip snoop hit", 3'd0, 0, 0, 2'b10, 0, 32'h204, 2'b00);

      op1("R2 reserve 0x300", 3'd3, 32'h300);
      apply("R7 cancel pin 0", 3'd0, 0, 0, 2'b00, 0, 0, 2'b01);
      op1("R2 reserve 0x300", 3'd3, 32'h300);
      apply("R7 cancel pin 1", 3'd0, 0, 0, 2'b00, 0, 0, 2'b10);

      op1("R2 reserve 0x300", 3'd3, 32'h300);
      apply("R8 sc with snoop hit", 3'd4, 32'h300, 32'h1234, 2'b01, 32'h308, 0, 2'b00);
      op1("R2 reserve 0x300", 3'd3, 32'h300);
      apply("R8 sc with cancel pin", 3'd4, 32'h300, 32'h1234, 2'b00, 0, 0, 2'b01);

      op1("R2 reserve 0x300", 3'd3, 32'h300);
      apply("R9 new reserve, snoop old", 3'd3, 32'h400, 0, 2'b01, 32'h300, 0, 2'b00);
      apply("R9 old granule ignored", 3'd0, 0, 0, 2'b10, 0, 32'h30C, 2'b00);
      apply("R3 sc after replace", 3'd4, 32'h900, 32'hBEEF, 2'b00, 0, 0, 2'b00);
      apply("R9 reserve with pin", 3'd3, 32'h500, 0, 2'b00, 0, 0, 2'b10);
      apply("R9 reserve with new-hit", 3'd3, 32'h600, 0, 2'b10, 0, 32'h608, 2'b00);
      op1("R9 reserve 0x700", 3'd3, 32'h700);
      apply("R9 replaced, new granule hit", 3'd0, 0, 0, 2'b01, 32'h70C, 0, 2'b00);

      // back-to-back store-conditionals give one done pulse each (R11)
      op1("R2 reserve 0xA00", 3'd3, 32'hA00);
      op1("R11 sc pulse one", 3'd4, 32'hA00);
      op1("R11 sc pulse two", 3'd4, 32'hA00);

      repeat (3) @(negedge clk);
      chk("R11 sc_done idle", sc_done, 0);
      chk("R11 scoreboard drained", sb_q.size(), 0);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule